// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Promotable Maskable Source

This block decides which interrupt request a small 8-bit CPU should take next. It watches six non-maskable request lines and fifteen maskable ones. It raises a single request line to the CPU and gives the index of the winning source. It also holds the state that decides whether maskable sources may be taken: the global mask bit (I), the enable bit of the gated non-maskable line (X), a 4-bit promotion field, and the mode of the external IRQ pin.

The CPU core owns instruction execution, stacking and the vector fetch. It drives strobes into this block: set mask, clear mask, return-from-interrupt (which carries the stacked I and X values) and acknowledge (which carries the index being serviced). Register writes load the promotion field, the pin mode and the X bit. The request and index outputs are combinational from the registered state and the raw request lines, so the CPU sees a change in the same cycle it happens.

The X bit is held in a three-state machine:
- X_ARMED is the reset state, with X=1. A software write of 0 to X moves it to X_OPEN.
- X_OPEN has X=0. An acknowledge of the gated line moves it to X_HELD.
- X_HELD has X=1. A return with stacked X=0, or a software write of 0 to X, moves it back to X_OPEN.

The IRQ pin follower has two states, LINE_HIGH and LINE_LOW. It moves to whichever level the pin shows at each clock edge. A clock edge taken in LINE_HIGH with the pin low is a falling edge.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, I=1, X=1, the promotion field is 0, the IRQ pin is in level mode, and with no request line active int_req=0.
- R2: The I bit changes at a clock edge as follows. A return strobe loads I from rti_i. Otherwise an acknowledge or a set strobe makes I=1. Otherwise a clear strobe makes I=0.
- R3: While I=1, no maskable source raises int_req. A level source that is still active, or an edge flag that is still pending, is taken once I is cleared.
- R4: Non-maskable lines 0 to 4 request regardless of I and X. The lowest index wins, and int_id equals that index.
- R5: Non-maskable line 5 requests only while X=0. It outranks every maskable source. An acknowledge with ack_id=5 makes X=1 and I=1. A return with rti_x=0 makes X=0 again.
- R6: Writing x_wdata=0 with x_wr makes X=0. Writing x_wdata=1 never raises X.
- R7: Maskable source m maps to int_id 6+m. Source 0 is the IRQ pin. Sources 1 to 14 come from msk_req[m-1]. Without promotion, the lowest m wins.
- R8: A promotion value v from 0 to 14 makes maskable source v win over all other maskable sources. The value 15 promotes nothing.
- R9: A promotion write updates the field only when I=1 before the edge. Otherwise the write is ignored.
- R10: In level mode (mode value 0), the IRQ source is active in the same cycle that irq_n is low.
- R11: In edge mode (mode value 1), a high-to-low change of irq_n between two clock edges sets a pending flag, visible after the second edge. The flag is cleared by an acknowledge with ack_id=6 (a new falling edge in the same cycle wins). It is also cleared by any mode write, which takes precedence over everything. A pin held low with no new falling edge does not request.
- R12: int_req is high in the same cycle that an enabled source is active. int_id is a valid index (below 21) while int_req is high, and is 0 while int_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 6 | Non-maskable request lines; line 5 is gated by X |
| irq_n | input | 1 | External IRQ pin, active low |
| msk_req | input | 14 | Maskable requests for sources 1..14 |
| set_mask | input | 1 | Set-I strobe |
| clr_mask | input | 1 | Clear-I strobe |
| rti | input | 1 | Return-from-interrupt strobe |
| rti_i | input | 1 | Stacked I value restored on return |
| rti_x | input | 1 | Stacked X value restored on return |
| ack | input | 1 | CPU acknowledges the source in ack_id |
| ack_id | input | 5 | Index being acknowledged |
| hprio_wr | input | 1 | Promotion field write strobe |
| hprio_wdata | input | 4 | Promotion field write data |
| mode_wr | input | 1 | IRQ pin mode write strobe |
| mode_wdata | input | 1 | 0 = level mode, 1 = falling-edge mode |
| x_wr | input | 1 | X bit write strobe |
| x_wdata | input | 1 | X bit write data; only 0 has an effect |
| int_req | output | 1 | Interrupt request to the CPU |
| int_id | output | 5 | Index of the winning source |
| i_bit | output | 1 | Current global mask bit |
| x_bit | output | 1 | Current X bit |

## Verification
A wrong I bit or X-machine state shows up at the ports in the very next cycle: i_bit or x_bit differs, and int_req appears or vanishes for a source that should be blocked or passed. A corrupted promotion field stays hidden until two maskable sources are active together. At that point int_id names the wrong winner in the same cycle. A lost or stuck edge flag shows up one cycle after the falling edge, or after the acknowledge that should have cleared it. The bench therefore compares all four outputs against its own model on every clock, and stimulus is arranged so that each hidden state is exposed soon after it changes.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // X bit life cycle
    typedef enum logic [1:0] {
        X_ARMED = 2'd0,
        X_OPEN  = 2'd1,
        X_HELD  = 2'd2
    } xstate_e;

    // last sampled level of the external pin
    typedef enum logic {
        LINE_HIGH = 1'b0,
        LINE_LOW  = 1'b1
    } line_e;

endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int N = 6,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec[k]) begin
                idx = W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_mask_pick.sv
module irq_mask_pick #(
    parameter int MSK_N = 15,
    parameter int SEL_W = 4
) (
    input  logic [MSK_N-1:0] src,
    input  logic [SEL_W-1:0] sel,
    output logic             found,
    output logic [SEL_W-1:0] idx
);
    logic [MSK_N-1:0] promo_vec;
    logic             promo_hit;
    logic             base_found;
    logic [SEL_W-1:0] base_idx;

    // one-hot match of the promoted source
    for (genvar g = 0; g < MSK_N; g++) begin : g_promo
        assign promo_vec[g] = src[g] && (sel == SEL_W'(g));
    end

    assign promo_hit = |promo_vec;

    irq_first_set #(
        .N (MSK_N),
        .W (SEL_W)
    ) u_base (
        .vec   (src),
        .found (base_found),
        .idx   (base_idx)
    );

    assign found = base_found;
    assign idx   = promo_hit ? sel : base_idx;
endmodule

// File: rtl/irq_xbit_fsm.sv
module irq_xbit_fsm
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x_clear,
    input  logic x_ack,
    input  logic rti,
    input  logic rti_x,
    output logic x_bit,
    output logic x_open
);
    xstate_e state_q;
    xstate_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= X_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            X_ARMED: if (x_clear) state_d = X_OPEN;
            X_OPEN:  if (x_ack)   state_d = X_HELD;
            X_HELD:  if (x_clear || (rti && !rti_x)) state_d = X_OPEN;
            default: state_d = X_ARMED;
        endcase
    end

    always_comb begin
        x_open = 1'b0;
        unique case (state_q)
            X_ARMED: x_open = 1'b0;
            X_OPEN:  x_open = 1'b1;
            X_HELD:  x_open = 1'b0;
            default: x_open = 1'b0;
        endcase
        x_bit = !x_open;
    end
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
    import irq_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic edge_mode,
    input  logic mode_wr,
    input  logic ack_pin,
    output logic active
);
    line_e line_q;
    line_e line_d;
    logic  fall;
    logic  pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= LINE_HIGH;
        end else begin
            line_q <= line_d;
        end
    end

    always_comb begin
        line_d = irq_n ? LINE_HIGH : LINE_LOW;
        fall   = 1'b0;
        unique case (line_q)
            LINE_HIGH: fall = !irq_n;
            LINE_LOW:  fall = 1'b0;
            default:   fall = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (mode_wr) begin
            pend_q <= 1'b0;
        end else if (fall) begin
            pend_q <= 1'b1;
        end else if (ack_pin) begin
            pend_q <= 1'b0;
        end
    end

    assign active = edge_mode ? pend_q : !irq_n;
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
    parameter int NMI_N = 6,
    parameter int MSK_N = 15
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NMI_N-1:0]                       nmi_req,
    input  logic                                   irq_n,
    input  logic [MSK_N-2:0]                       msk_req,
    input  logic                                   set_mask,
    input  logic                                   clr_mask,
    input  logic                                   rti,
    input  logic                                   rti_i,
    input  logic                                   rti_x,
    input  logic                                   ack,
    input  logic [$clog2(NMI_N+MSK_N)-1:0]         ack_id,
    input  logic                                   hprio_wr,
    input  logic [$clog2(MSK_N+1)-1:0]             hprio_wdata,
    input  logic                                   mode_wr,
    input  logic                                   mode_wdata,
    input  logic                                   x_wr,
    input  logic                                   x_wdata,
    output logic                                   int_req,
    output logic [$clog2(NMI_N+MSK_N)-1:0]         int_id,
    output logic                                   i_bit,
    output logic                                   x_bit
);
    localparam int ID_W     = $clog2(NMI_N + MSK_N);
    localparam int SEL_W    = $clog2(MSK_N + 1);
    localparam int NMI_W    = $clog2(NMI_N);
    localparam int XIRQ_IDX = NMI_N - 1;
    localparam int PIN_ID   = NMI_N;

    logic             i_q;
    logic [SEL_W-1:0] sel_q;
    logic             edge_q;
    logic             x_open;
    logic             pin_active;
    logic [NMI_N-1:0] nmi_eff;
    logic [MSK_N-1:0] msk_src;
    logic             nmi_found;
    logic [NMI_W-1:0] nmi_idx;
    logic             m_found;
    logic [SEL_W-1:0] m_idx;

    // global mask bit: return, then set-type, then clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= 1'b1;
        end else if (rti) begin
            i_q <= rti_i;
        end else if (ack || set_mask) begin
            i_q <= 1'b1;
        end else if (clr_mask) begin
            i_q <= 1'b0;
        end
    end

    // promotion field: writable only while masked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (hprio_wr && i_q) begin
            sel_q <= hprio_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
        end else if (mode_wr) begin
            edge_q <= mode_wdata;
        end
    end

    irq_xbit_fsm u_xfsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_clear (x_wr && !x_wdata),
        .x_ack   (ack && (ack_id == ID_W'(XIRQ_IDX))),
        .rti     (rti),
        .rti_x   (rti_x),
        .x_bit   (x_bit),
        .x_open  (x_open)
    );

    irq_pin_cond u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_n     (irq_n),
        .edge_mode (edge_q),
        .mode_wr   (mode_wr),
        .ack_pin   (ack && (ack_id == ID_W'(PIN_ID))),
        .active    (pin_active)
    );

    always_comb begin
        nmi_eff           = nmi_req;
        nmi_eff[XIRQ_IDX] = nmi_req[XIRQ_IDX] && x_open;
        msk_src           = {msk_req, pin_active};
    end

    irq_first_set #(
        .N (NMI_N),
        .W (NMI_W)
    ) u_nmi (
        .vec   (nmi_eff),
        .found (nmi_found),
        .idx   (nmi_idx)
    );

    irq_mask_pick #(
        .MSK_N (MSK_N),
        .SEL_W (SEL_W)
    ) u_mpick (
        .src   (msk_src),
        .sel   (sel_q),
        .found (m_found),
        .idx   (m_idx)
    );

    always_comb begin
        int_req = 1'b0;
        int_id  = '0;
        if (nmi_found) begin
            int_req = 1'b1;
            int_id  = ID_W'(nmi_idx);
        end else if (!i_q && m_found) begin
            int_req = 1'b1;
            int_id  = ID_W'(PIN_ID) + ID_W'(m_idx);
        end
    end

    assign i_bit = i_q;
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
    parameter int NMI_N = 6,
    parameter int MSK_N = 15
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NMI_N-1:0]               nmi_req,
    input logic                           rti,
    input logic                           rti_i,
    input logic                           ack,
    input logic [$clog2(NMI_N+MSK_N)-1:0] ack_id,
    input logic                           hprio_wr,
    input logic [$clog2(MSK_N+1)-1:0]     sel_q,
    input logic                           int_req,
    input logic [$clog2(NMI_N+MSK_N)-1:0] int_id,
    input logic                           i_bit,
    input logic                           x_bit
);
    localparam int ID_W  = $clog2(NMI_N + MSK_N);
    localparam int XI    = NMI_N - 1;
    localparam int TOTAL = NMI_N + MSK_N;

    p_id_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (int_id < ID_W'(TOTAL)));

    p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req |-> (int_id == '0));

    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (i_bit && (nmi_req == '0)) |-> !int_req);

    p_nmi_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req[0] |-> (int_req && (int_id == '0)));

    p_rti_restore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rti |=> (i_bit == $past(rti_i)));

    p_x_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x_bit) |-> $past(ack && (ack_id == ID_W'(XI))));

    p_xirq_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req[XI] && !x_bit && (nmi_req[XI-1:0] == '0)) |-> (int_req && (int_id == ID_W'(XI))));

    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hprio_wr || !i_bit) |=> (sel_q == $past(sel_q)));
endmodule

bind irq_prio_arbiter irq_arb_checker #(
    .NMI_N (NMI_N),
    .MSK_N (MSK_N)
) u_arb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_req  (nmi_req),
    .rti      (rti),
    .rti_i    (rti_i),
    .ack      (ack),
    .ack_id   (ack_id),
    .hprio_wr (hprio_wr),
    .sel_q    (sel_q),
    .int_req  (int_req),
    .int_id   (int_id),
    .i_bit    (i_bit),
    .x_bit    (x_bit)
);

// File: tb/test_irq_prio_arbiter.sv
module test_irq_prio_arbiter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  nmi_req = '0;
    logic        irq_n = 1'b1;
    logic [13:0] msk_req = '0;
    logic        set_mask = 1'b0;
    logic        clr_mask = 1'b0;
    logic        rti = 1'b0;
    logic        rti_i = 1'b0;
    logic        rti_x = 1'b0;
    logic        ack = 1'b0;
    logic [4:0]  ack_id = '0;
    logic        hprio_wr = 1'b0;
    logic [3:0]  hprio_wdata = '0;
    logic        mode_wr = 1'b0;
    logic        mode_wdata = 1'b0;
    logic        x_wr = 1'b0;
    logic        x_wdata = 1'b0;
    logic        int_req;
    logic [4:0]  int_id;
    logic        i_bit;
    logic        x_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_i, m_xs, m_sel, m_edge, m_prev, m_pend;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_prio_arbiter i_irq_prio_arbiter (
        .clk (clk), .rst_n (rst_n), .nmi_req (nmi_req), .irq_n (irq_n),
        .msk_req (msk_req), .set_mask (set_mask), .clr_mask (clr_mask),
        .rti (rti), .rti_i (rti_i), .rti_x (rti_x), .ack (ack), .ack_id (ack_id),
        .hprio_wr (hprio_wr), .hprio_wdata (hprio_wdata), .mode_wr (mode_wr),
        .mode_wdata (mode_wdata), .x_wr (x_wr), .x_wdata (x_wdata),
        .int_req (int_req), .int_id (int_id), .i_bit (i_bit), .x_bit (x_bit)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_i = 1; m_xs = 0; m_sel = 0; m_edge = 0; m_prev = 1; m_pend = 0;
    endtask

    // x state: 0 armed, 1 open, 2 held
    task automatic model_step();
        int ni, nxs, nsel, npend;
        bit fall;
        ni = m_i;
        if (rti) ni = rti_i;
        else if (ack || set_mask) ni = 1;
        else if (clr_mask) ni = 0;
        nsel = m_sel;
        if (hprio_wr && m_i == 1) nsel = hprio_wdata;
        nxs = m_xs;
        if (m_xs == 0 && x_wr && !x_wdata) nxs = 1;
        if (m_xs == 1 && ack && ack_id == 5) nxs = 2;
        if (m_xs == 2 && ((x_wr && !x_wdata) || (rti && !rti_x))) nxs = 1;
        fall = (m_prev == 1) && !irq_n;
        npend = m_pend;
        if (mode_wr) npend = 0;
        else if (fall) npend = 1;
        else if (ack && ack_id == 6) npend = 0;
        if (mode_wr) m_edge = mode_wdata;
        m_prev = irq_n;
        m_i = ni; m_xs = nxs; m_sel = nsel; m_pend = npend;
    endtask

    task automatic compare(string tag);
        int ereq, eid;
        bit [14:0] src;
        ereq = 0; eid = 0;
        for (int n = 0; n < 6; n++) begin
            if (ereq == 0 && nmi_req[n] && (n != 5 || m_xs == 1)) begin
                ereq = 1; eid = n;
            end
        end
        if (ereq == 0 && m_i == 0) begin
            src[0] = m_edge ? m_pend[0] : !irq_n;
            for (int k = 1; k < 15; k++) src[k] = msk_req[k-1];
            if (m_sel < 15 && src[m_sel]) begin
                ereq = 1; eid = 6 + m_sel;
            end else begin
                for (int k = 14; k >= 0; k--) begin
                    if (src[k]) begin
                        ereq = 1; eid = 6 + k;
                    end
                end
            end
        end
        check(tag, "int_req (R12)", int'(int_req), ereq);
        check(tag, "int_id", int'(int_id), eid);
        check(tag, "i_bit", int'(i_bit), m_i);
        check(tag, "x_bit", int'(x_bit), (m_xs == 1) ? 0 : 1);
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
        @(negedge clk);
        set_mask = 0; clr_mask = 0; rti = 0; ack = 0; hprio_wr = 0;
        mode_wr = 0; x_wr = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", "i_bit", int'(i_bit), 1);
        check("R1", "x_bit", int'(x_bit), 1);
        check("R1", "int_req", int'(int_req), 0);
        @(negedge clk);
        tick("R1");

        // level pin held while masked, then released
        irq_n = 0;                      tick("R3");
        clr_mask = 1;                   tick("R10");
        tick("R10");
        irq_n = 1; msk_req[2] = 1; msk_req[4] = 1;  tick("R7");
        hprio_wr = 1; hprio_wdata = 5;  tick("R9");
        set_mask = 1;                   tick("R3");
        hprio_wr = 1; hprio_wdata = 5;  tick("R9");
        clr_mask = 1;                   tick("R8");
        irq_n = 0;                      tick("R8");
        set_mask = 1;                   tick("R8");
        hprio_wr = 1; hprio_wdata = 15; tick("R8");
        clr_mask = 1;                   tick("R8");
        irq_n = 1;                      tick("R7");

        // fixed non-maskable lines
        nmi_req[2] = 1; set_mask = 1;   tick("R4");
        nmi_req[1] = 1;                 tick("R4");
        nmi_req = '0;                   tick("R4");

        // gated non-maskable line and X bit
        nmi_req[5] = 1;                 tick("R5");
        x_wr = 1; x_wdata = 0;          tick("R6");
        clr_mask = 1;                   tick("R5");
        ack = 1; ack_id = 5;            tick("R5");
        x_wr = 1; x_wdata = 1;          tick("R6");
        rti = 1; rti_i = 0; rti_x = 0;  tick("R2");
        nmi_req[5] = 0; x_wr = 1; x_wdata = 1; tick("R6");

        // mask precedence
        set_mask = 1; clr_mask = 1;     tick("R2");
        rti = 1; rti_i = 0; set_mask = 1; tick("R2");
        ack = 1; ack_id = 3; clr_mask = 1; tick("R2");
        msk_req = '0; clr_mask = 1;     tick("R12");

        // edge mode
        mode_wr = 1; mode_wdata = 1;    tick("R11");
        irq_n = 0;                      tick("R11");
        irq_n = 1;                      tick("R11");
        tick("R11");
        ack = 1; ack_id = 6;            tick("R11");
        clr_mask = 1;                   tick("R11");
        irq_n = 0;                      tick("R11");
        mode_wr = 1; mode_wdata = 1;    tick("R11");
        tick("R11");
        mode_wr = 1; mode_wdata = 0;    tick("R10");
        irq_n = 1;                      tick("R12");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule